// File: doc/BRIEF.md
# Parallel bus wait-state controller

This block times accesses on a simple parallel peripheral bus. The bus has three decoded chip-select ranges and one default range that has no chip select. A host presents a request on a valid/ready port, tagged with the range it falls in. The block asserts the matching chip select at its programmed level and raises the strobe. It holds the strobe for the number of timing ticks programmed for that range. It then drops the strobe and the chip select and pulses a done flag for one clock.

One 32-bit control word is written and read over a plain register port. It holds a 3-bit tick count for each range and a 2-bit clock divisor, which turns the block clock into the timing tick. It also holds a level setting for each chip-select output, each of four interrupt inputs, and one host interrupt line. The interrupt inputs leave the block as active-high signals.

A strap input is sampled while reset is held. A strap of 1 selects peripheral-bus mode, in which the block behaves as described above. A strap of 0 selects the alternate arbiter mode. In arbiter mode the request port is never ready and the control word reads back as a fixed mode marker. The request port has no back-pressure of its own beyond `req_ready`: `req_ready` is high only while no access is in progress, and a request is taken on the first edge on which `req_valid` and `req_ready` are both high.

Top module: `pbus_wait_ctrl`

## Requirements
- R1: After reset with the strap at 1, the control word reads 0x00000000, `req_ready` is 1, `acc_strobe` and `acc_done` are 0, and all three chip selects sit at their inactive level, which is high.
- R2: In peripheral-bus mode, bits 13:0 and 31:24 of the control word read back the last value written. Bits 22:14 and bit 23 always read 0.
- R3: With the strap at 0 during reset, the control word reads 0x00800000 (only bit 23 set), `req_ready` stays 0, and no access ever starts.
- R4: The access tick count comes from bits 2:0 for `req_sel`=0, bits 5:3 for `req_sel`=1, bits 8:6 for `req_sel`=2, and bits 11:9 for `req_sel`=3 (no chip select).
- R5: Bits 13:12 give the divisor: code 0, 1, 2 or 3 divides by 1, 2, 3 or 4. The strobe stays high for exactly count × divisor clock cycles, starting in the cycle after the accepting edge.
- R6: A count field of 0 acts as one tick.
- R7: `acc_done` is high for exactly one cycle, in the first cycle after the strobe falls. In that cycle the strobe is low and every chip select is inactive.
- R8: During an access, only chip select `req_sel` is asserted, at the level in bit 28+`req_sel` (0 = low, 1 = high). A `req_sel` of 3 asserts none. An inactive chip select drives the inverse of its level bit.
- R9: `irq_act[i]` is high when `irq_raw[i]` equals bit 24+i. `host_irq_act` is high when `host_irq_raw` equals bit 31.
- R10: `req_ready` is 0 while the strobe is high. A request held during an access is not taken and does not change that access.
- R11: A write made during an access changes neither its length nor its chip-select levels. The new value applies from the next access on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; strap sampled while low |
| mode_strap | input | 1 | 1 selects peripheral-bus mode, 0 arbiter mode |
| cfg_wr_en | input | 1 | Control word write enable |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request ready (idle) |
| req_sel | input | 2 | Range of the request: 0..2 chip select, 3 none |
| acc_done | output | 1 | One-cycle completion pulse |
| acc_strobe | output | 1 | Access strobe, high for the access length |
| cs_out | output | 3 | Chip-select outputs at programmed levels |
| irq_raw | input | 4 | Interrupt inputs from peripherals |
| irq_act | output | 4 | Interrupts normalised to active high |
| host_irq_raw | input | 1 | Host interrupt line used as an input |
| host_irq_act | output | 1 | Host interrupt normalised to active high |

## Verification
The bench builds the block with the default parameters: three chip-select ranges, 3-bit tick counts and a 2-bit divisor code. Every count and divisor pair can therefore be reached, and the longest access is 28 cycles, so lengths are measured exactly rather than bounded. Directed cases cover a zero count, each range with its own count field, and all four divisors. They also cover a request held during an access, a write made mid-access, and arbiter mode. Random control words and ranges then mix levels and lengths.

// File: rtl/pbus_wait_pkg.sv
package pbus_wait_pkg;
  localparam int REG_W        = 32;
  localparam int NUM_CS       = 3;
  localparam int CNT_W        = 3;
  localparam int DIV_W        = 2;
  localparam int NUM_IRQ      = 4;
  localparam int NUM_RANGE    = NUM_CS + 1;
  localparam int SEL_W        = $clog2(NUM_RANGE);
  localparam int DIV_LSB      = NUM_RANGE * CNT_W;
  localparam int RSVD_LSB     = DIV_LSB + DIV_W;
  localparam int MODE_BIT     = 23;
  localparam int IRQ_POL_LSB  = 24;
  localparam int CS_POL_LSB   = IRQ_POL_LSB + NUM_IRQ;
  localparam int HIRQ_POL_BIT = CS_POL_LSB + NUM_CS;

  typedef enum logic {ST_IDLE, ST_BUSY} acc_state_e;

  function automatic logic [REG_W-1:0] wr_mask_f();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < RSVD_LSB; i++) m[i] = 1'b1;
    for (int i = IRQ_POL_LSB; i < REG_W; i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] WR_MASK = wr_mask_f();
endpackage

// File: rtl/pbus_cfg_reg.sv
module pbus_cfg_reg
  import pbus_wait_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_strap,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic [W-1:0] cfg_q,
  output logic         bus_mode
);
  logic mode_q;
  logic [W-1:0] word_q;

  // strap captured on every edge while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_strap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (wr_en) word_q <= wdata & W'(WR_MASK);
  end

  assign bus_mode = mode_q;
  assign cfg_q    = word_q;
  assign rdata    = mode_q ? word_q : (W'(1) << MODE_BIT);
endmodule

// File: rtl/pbus_tick_div.sv
module pbus_tick_div #(
  parameter int DW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic [DW-1:0] div_code,
  output logic          tick
);
  logic [DW-1:0] phase_q;

  // divisor is code+1: the tick fires when the phase reaches the code
  assign tick = run && (phase_q == div_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (run)     phase_q <= tick ? '0 : phase_q + 1'b1;
    else              phase_q <= '0;
  end
endmodule

// File: rtl/pbus_access_fsm.sv
module pbus_access_fsm
  import pbus_wait_pkg::*;
#(
  parameter int NCS = NUM_CS,
  parameter int CW  = CNT_W,
  parameter int DW  = DIV_W,
  parameter int SW  = SEL_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_mode,
  input  logic           req_valid,
  input  logic [SW-1:0]  req_sel,
  input  logic [CW-1:0]  sel_cnt,
  input  logic [DW-1:0]  div_live,
  input  logic [NCS-1:0] pol_live,
  input  logic           tick,
  output logic           req_ready,
  output logic           restart,
  output logic           busy,
  output logic [DW-1:0]  div_lat,
  output logic           done,
  output logic [NCS-1:0] cs_out
);
  acc_state_e    state_q;
  logic [CW-1:0] target_q, ticks_q;
  logic [SW-1:0] sel_q;
  logic [NCS-1:0] pol_q, pol_src;
  logic          done_q, last_tick;

  assign busy      = (state_q == ST_BUSY);
  assign req_ready = bus_mode && !busy;
  assign restart   = req_valid && req_ready;
  assign last_tick = busy && tick && (ticks_q == target_q - 1'b1);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      target_q <= '0;
      ticks_q  <= '0;
      sel_q    <= '0;
      pol_q    <= '0;
      div_lat  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (restart) begin
        state_q  <= ST_BUSY;
        target_q <= (sel_cnt == '0) ? CW'(1) : sel_cnt;
        ticks_q  <= '0;
        sel_q    <= req_sel;
        pol_q    <= pol_live;
        div_lat  <= div_live;
      end else if (last_tick) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
      end else if (busy && tick) begin
        ticks_q <= ticks_q + 1'b1;
      end
    end
  end

  assign pol_src = busy ? pol_q : pol_live;

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign cs_out[g] = (busy && sel_q == SW'(g)) ? pol_q[g] : ~pol_src[g];
  end
endmodule

// File: rtl/pbus_irq_norm.sv
module pbus_irq_norm #(
  parameter int N = 5
) (
  input  logic [N-1:0] raw,
  input  logic [N-1:0] level,
  output logic [N-1:0] act
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    assign act[g] = (raw[g] == level[g]);
  end
endmodule

// File: rtl/pbus_wait_ctrl.sv
module pbus_wait_ctrl
  import pbus_wait_pkg::*;
#(
  parameter int NCS = NUM_CS,
  parameter int NIRQ = NUM_IRQ
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_strap,
  input  logic              cfg_wr_en,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  req_sel,
  output logic              acc_done,
  output logic              acc_strobe,
  output logic [NCS-1:0]    cs_out,
  input  logic [NIRQ-1:0]   irq_raw,
  output logic [NIRQ-1:0]   irq_act,
  input  logic              host_irq_raw,
  output logic              host_irq_act
);
  localparam int NR = NCS + 1;

  logic [REG_W-1:0] cfg_q;
  logic             bus_mode, tick, restart, busy;
  logic [DIV_W-1:0] div_lat;
  logic [CNT_W-1:0] cnt_arr [NR];

  for (genvar g = 0; g < NR; g++) begin : g_cnt
    assign cnt_arr[g] = cfg_q[g*CNT_W +: CNT_W];
  end

  pbus_cfg_reg #(.W(REG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap),
    .wr_en(cfg_wr_en), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .cfg_q(cfg_q), .bus_mode(bus_mode)
  );

  pbus_tick_div #(.DW(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(restart), .run(busy),
    .div_code(div_lat), .tick(tick)
  );

  pbus_access_fsm #(.NCS(NCS), .CW(CNT_W), .DW(DIV_W), .SW(SEL_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode),
    .req_valid(req_valid), .req_sel(req_sel),
    .sel_cnt(cnt_arr[req_sel]),
    .div_live(cfg_q[DIV_LSB +: DIV_W]),
    .pol_live(cfg_q[CS_POL_LSB +: NCS]),
    .tick(tick), .req_ready(req_ready), .restart(restart),
    .busy(busy), .div_lat(div_lat), .done(acc_done), .cs_out(cs_out)
  );

  assign acc_strobe = busy;

  pbus_irq_norm #(.N(NIRQ + 1)) u_irq (
    .raw({host_irq_raw, irq_raw}),
    .level({cfg_q[HIRQ_POL_BIT], cfg_q[IRQ_POL_LSB +: NIRQ]}),
    .act({host_irq_act, irq_act})
  );
endmodule

// File: rtl/pbus_wait_ctrl_chk.sv
module pbus_wait_ctrl_chk
  import pbus_wait_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             acc_done,
  input logic             acc_strobe,
  input logic [NUM_CS-1:0]  cs_out,
  input logic [REG_W-1:0] cfg_rdata,
  input logic [NUM_IRQ-1:0] irq_raw,
  input logic [NUM_IRQ-1:0] irq_act,
  input logic             host_irq_raw,
  input logic             host_irq_act
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !acc_done); // R7
  AST_DONE_STROBE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |-> !acc_strobe); // R7
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |-> $past(acc_strobe)); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_strobe |-> !req_ready); // R10
  AST_STROBE_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_strobe) |-> $past(req_valid && req_ready)); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[MODE_BIT-1:RSVD_LSB] == '0); // R2
  AST_ARB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[MODE_BIT] |-> (!req_ready && !acc_strobe)); // R3
  AST_IRQ_NORM: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[MODE_BIT] |-> (irq_act == (irq_raw ~^ cfg_rdata[IRQ_POL_LSB +: NUM_IRQ])
                              && host_irq_act == (host_irq_raw ~^ cfg_rdata[HIRQ_POL_BIT]))); // R9
  AST_CS_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_strobe && !cfg_rdata[MODE_BIT]) |-> cs_out == ~cfg_rdata[CS_POL_LSB +: NUM_CS]); // R8
endmodule

bind pbus_wait_ctrl pbus_wait_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .acc_done(acc_done), .acc_strobe(acc_strobe), .cs_out(cs_out),
  .cfg_rdata(cfg_rdata), .irq_raw(irq_raw), .irq_act(irq_act),
  .host_irq_raw(host_irq_raw), .host_irq_act(host_irq_act)
);

// File: tb/sim_pbus_wait_ctrl.sv
`timescale 1ns/1ps
module sim_pbus_wait_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_strap = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_sel = '0;
  logic        acc_done, acc_strobe;
  logic [2:0]  cs_out;
  logic [3:0]  irq_raw = '0;
  logic [3:0]  irq_act;
  logic        host_irq_raw = 1'b0;
  logic        host_irq_act;

  int checks = 0;
  int failures = 0;
  logic [31:0] shadow = '0;
  localparam logic [31:0] MASK = 32'hFF00_3FFF;

  always #4 clk = ~clk;

  pbus_wait_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap),
    .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
    .acc_done(acc_done), .acc_strobe(acc_strobe), .cs_out(cs_out),
    .irq_raw(irq_raw), .irq_act(irq_act),
    .host_irq_raw(host_irq_raw), .host_irq_act(host_irq_act)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [31:0] w, input logic [1:0] sel);
    int c = int'((w >> (3 * sel)) & 32'h7);
    if (c == 0) c = 1;
    return c * (int'(w[13:12]) + 1);
  endfunction

  function automatic logic [2:0] exp_cs(input logic [2:0] pol, input logic [1:0] sel, input bit active);
    logic [2:0] r;
    for (int i = 0; i < 3; i++) r[i] = (active && sel == 2'(i)) ? pol[i] : ~pol[i];
    return r;
  endfunction

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; mode_strap = strap; req_valid = 1'b0; cfg_wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    shadow = '0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] v);
    cfg_wr_en = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    shadow = v & MASK;
  endtask

  task automatic check_irq(input logic [3:0] raw, input logic hraw);
    irq_raw = raw; host_irq_raw = hraw;
    #1;
    chk(irq_act == (raw ~^ shadow[27:24]), "R9 irq", 32'(irq_act), 32'(raw ~^ shadow[27:24]));
    chk(host_irq_act == (hraw ~^ shadow[31]), "R9 host irq", 32'(host_irq_act), 32'(hraw ~^ shadow[31]));
  endtask

  // one access: hold request for 'hold' busy cycles; optional write in first busy cycle
  task automatic run_access(input logic [1:0] sel, input int hold, input bit do_wr,
                            input logic [31:0] wval, input string tag);
    int len = exp_len(shadow, sel);
    logic [2:0] pol = shadow[30:28];
    int n = 0;
    bit cs_ok = 1'b1;
    logic [2:0] bad_cs = '0;
    chk(req_ready == 1'b1, "R10 ready when idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_sel = sel;
    @(negedge clk);
    while (acc_strobe && n < 100) begin
      if (cs_out !== exp_cs(pol, sel, 1'b1)) begin cs_ok = 1'b0; bad_cs = cs_out; end
      if (n < hold) chk(req_ready == 1'b0, "R10 not ready while busy", 32'(req_ready), 32'd0);
      if (n + 1 >= hold) req_valid = 1'b0;
      req_sel = sel ^ 2'b01;
      if (n == 0 && do_wr) begin cfg_wr_en = 1'b1; cfg_wdata = wval; end
      else cfg_wr_en = 1'b0;
      n++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (cfg_wr_en) cfg_wr_en = 1'b0;
    if (do_wr) shadow = wval & MASK;
    chk(n == len, {tag, " strobe length"}, 32'(n), 32'(len));
    chk(cs_ok, "R8 active chip selects", 32'(bad_cs), 32'(exp_cs(pol, sel, 1'b1)));
    chk(acc_done == 1'b1, "R7 done pulse", 32'(acc_done), 32'd1);
    chk(cs_out == exp_cs(shadow[30:28], sel, 1'b0), "R7 cs inactive at done",
        32'(cs_out), 32'(exp_cs(shadow[30:28], sel, 1'b0)));
    @(negedge clk);
    chk(acc_done == 1'b0, "R7 done one cycle", 32'(acc_done), 32'd0);
  endtask

  bit finished = 1'b0;

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset(1'b1);
    // R1 reset state
    chk(cfg_rdata == 32'h0, "R1 reset word", cfg_rdata, 32'h0);
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
    chk(acc_strobe == 1'b0 && acc_done == 1'b0, "R1 strobe/done", {acc_strobe, acc_done}, 32'd0);
    chk(cs_out == 3'b111, "R1 cs inactive", 32'(cs_out), 32'h7);

    // R2 readback mask
    wr(32'hFFFF_FFFF);
    chk(cfg_rdata == 32'hFF00_3FFF, "R2 readback ones", cfg_rdata, 32'hFF00_3FFF);
    wr(32'h5A5A_A5A5);
    chk(cfg_rdata == (32'h5A5A_A5A5 & MASK), "R2 readback pattern", cfg_rdata, 32'h5A5A_A5A5 & MASK);

    // R9 interrupt levels
    wr(32'hA500_0000);
    check_irq(4'b0101, 1'b1);
    check_irq(4'b1010, 1'b0);
    wr(32'h0000_0000);
    check_irq(4'b0011, 1'b0);

    // R6 zero count is one tick
    wr(32'h0000_0000);
    run_access(2'd0, 0, 1'b0, '0, "R6 zero count");
    wr(32'h0000_2000); // div code 2
    run_access(2'd3, 0, 1'b0, '0, "R6 zero count div3");

    // R4 each range uses its own field (counts 1,2,3,4), divisor 3, cs levels mixed
    wr(32'h5000_2000 | (32'd4 << 9) | (32'd3 << 6) | (32'd2 << 3) | 32'd1);
    for (int s = 0; s < 4; s++) run_access(2'(s), 0, 1'b0, '0, "R4 range field");

    // R5 all divisors with count 5 on range 3
    for (int d = 0; d < 4; d++) begin
      wr((32'd5 << 9) | (32'(d) << 12) | 32'h7000_0000);
      run_access(2'd3, 0, 1'b0, '0, "R5 divisor");
    end

    // R10 request held during access
    wr((32'd6 << 3) | (32'd1 << 12));
    run_access(2'd1, 3, 1'b0, '0, "R10 held request");

    // R11 write during access
    wr((32'd7 << 6) | (32'd3 << 12) | 32'h4000_0000);
    run_access(2'd2, 0, 1'b1, (32'd1 << 6) | 32'h0000_0000, "R11 mid-write old");
    run_access(2'd2, 0, 1'b0, '0, "R11 new value");

    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [31:0] v = $urandom;
      logic [1:0]  s = 2'($urandom % 4);
      wr(v);
      chk(cfg_rdata == (v & MASK), "R2 random readback", cfg_rdata, v & MASK);
      check_irq(4'($urandom), 1'($urandom));
      run_access(s, 0, 1'b0, '0, "R5 random access");
    end

    // R3 arbiter mode
    do_reset(1'b0);
    chk(cfg_rdata == 32'h0080_0000, "R3 arbiter word", cfg_rdata, 32'h0080_0000);
    wr(32'hFFFF_FFFF);
    chk(cfg_rdata == 32'h0080_0000, "R3 arbiter word after write", cfg_rdata, 32'h0080_0000);
    chk(req_ready == 1'b0, "R3 not ready", 32'(req_ready), 32'd0);
    req_valid = 1'b1; req_sel = 2'd0;
    repeat (4) @(negedge clk);
    chk(acc_strobe == 1'b0, "R3 no access", 32'(acc_strobe), 32'd0);
    req_valid = 1'b0;

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule